// File: doc/BRIEF.md
# Clock-Ready Interrupt Status Register

This block is a single 32-bit control word on a simple register bus. It collects one-cycle "ready" pulses from seven clock sources and one failure pulse from a clock-supervision circuit. Each source has a sticky status flag that hardware sets. Each ready source also has an interrupt enable that software can read and write. Every flag, including the failure flag, has a command bit that software writes with a one to clear the flag. The enabled ready flags are merged into one interrupt request. The failure flag drives its own interrupt output, which cannot be masked.

Software finds the word at byte offset 0x08 of the block's address window. Accesses finish in the cycle they are issued: a write takes effect on the next clock edge, and read data is combinational while the select is high. Byte strobes limit a write to the lanes selected. Because the three field groups sit in separate lanes, a write to one lane alone can clear flags without changing the enables, or the reverse. The bus here is a plain register strobe and not a stream, so it has no back-pressure. Each access completes in one cycle.

Top module: `clkrdy_intr_reg`

## Requirements
- R1: After reset the word reads as 0x00000000, and both interrupt outputs are low.
- R2: A one-cycle pulse on `src_ready_i[k]` (k = 0 low-speed internal, 1 low-speed external, 2 high-speed internal, 3 high-speed external, 4 PLL, 5 PLL2, 6 PLL3) sets flag bit k. A pulse on `css_fail_i` sets flag bit 7. Flags stay set until cleared.
- R3: Bits 14:8 hold the interrupt enables for ready flags 0..6, in the same order. They read back what was last written.
- R4: Writing 1 to bit 16+k clears flag k, for k = 0..7. Writing 0 to a clear bit leaves its flag as it was.
- R5: Clear bits 23:16, bit 15 and bits 31:24 always read as 0.
- R6: When a set pulse and a clear of the same flag arrive in the same cycle, the flag ends up set.
- R7: `irq_ready_o` is high exactly when some ready flag k (0..6) is set and its enable bit 8+k is set. The failure flag never drives `irq_ready_o`.
- R8: `irq_fail_o` is high whenever flag bit 7 is set, whatever the enables hold.
- R9: A write changes only bits in lanes whose byte strobe is high (lane n covers bits 8n+7:8n). Lane 0 (the flags) cannot be written at all.
- R10: Only an access whose word address equals 0x08 reaches the word. Writes elsewhere are ignored, and reads elsewhere return 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| src_ready_i | input | 7 | One-cycle ready pulses, one per clock source |
| css_fail_i | input | 1 | One-cycle clock failure pulse |
| bus_sel_i | input | 1 | Access strobe |
| bus_we_i | input | 1 | 1 = write, 0 = read |
| bus_addr_i | input | ADDR_W | Byte address |
| bus_be_i | input | 4 | Byte strobes for a write |
| bus_wdata_i | input | 32 | Write data |
| bus_rdata_o | output | 32 | Read data (combinational) |
| irq_ready_o | output | 1 | Masked OR of ready flags |
| irq_fail_o | output | 1 | Unmaskable clock failure interrupt |

## Verification
Set pulses, clears and enable writes all take effect at the first rising edge after they are presented. Both interrupt outputs are combinational from the flag and enable registers, so they move in that same edge's cycle. Read data is combinational and is valid while the select is held. The bench drives every stimulus on a falling edge, lets exactly one rising edge pass, and samples the interrupts and read data one time unit after the following release. Each result is therefore observed in the single cycle in which it is due.

// File: rtl/clkrdy_pkg.sv
package clkrdy_pkg;
  localparam int DATA_W    = 32;
  localparam int LANE_W    = 8;
  localparam int LANES     = DATA_W / LANE_W;
  localparam int NUM_RDY   = 7;
  localparam int NUM_FLAGS = NUM_RDY + 1;
  localparam int FAIL_IDX  = NUM_RDY;
  // lane assignment of the three field groups
  localparam int FLAG_LANE = 0;
  localparam int EN_LANE   = 1;
  localparam int CLR_LANE  = 2;
  localparam int EN_LSB    = EN_LANE * LANE_W;
  localparam int CLR_LSB   = CLR_LANE * LANE_W;
endpackage

// File: rtl/clkrdy_flag.sv
module clkrdy_flag (
  input  logic clk,
  input  logic rst_n,
  input  logic set_i,
  input  logic clr_i,
  output logic flag_o
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     flag_o <= 1'b0;
    else if (set_i) flag_o <= 1'b1;
    else if (clr_i) flag_o <= 1'b0;
  end

  assert_set_wins_R6: assert property (@(posedge clk) disable iff (!rst_n)
    set_i |=> flag_o);
  assert_clear_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_i && !set_i) |=> !flag_o);
  assert_sticky_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (!clr_i && !set_i) |=> $stable(flag_o));
endmodule

// File: rtl/clkrdy_enable.sv
module clkrdy_enable #(
  parameter int N = 7
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         wr_i,
  input  logic [N-1:0] wdata_i,
  output logic [N-1:0] en_o
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    en_o <= '0;
    else if (wr_i) en_o <= wdata_i;
  end

  assert_lane_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_i |=> $stable(en_o));
  assert_rw_R3: assert property (@(posedge clk) disable iff (!rst_n)
    wr_i |=> (en_o == $past(wdata_i)));
endmodule

// File: rtl/clkrdy_intr_reg.sv
module clkrdy_intr_reg
  import clkrdy_pkg::*;
#(
  parameter int ADDR_W     = 8,
  parameter int REG_OFFSET = 8
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [NUM_RDY-1:0]  src_ready_i,
  input  logic                css_fail_i,
  input  logic                bus_sel_i,
  input  logic                bus_we_i,
  input  logic [ADDR_W-1:0]   bus_addr_i,
  input  logic [LANES-1:0]    bus_be_i,
  input  logic [DATA_W-1:0]   bus_wdata_i,
  output logic [DATA_W-1:0]   bus_rdata_o,
  output logic                irq_ready_o,
  output logic                irq_fail_o
);
  localparam int WORD_LSB = $clog2(LANES);
  localparam logic [ADDR_W-WORD_LSB-1:0] WORD_IDX = (ADDR_W-WORD_LSB)'(REG_OFFSET >> WORD_LSB);

  logic                 addr_hit, wr_hit, rd_hit;
  logic [NUM_FLAGS-1:0] set_vec, clr_vec, flags;
  logic [NUM_RDY-1:0]   enables;
  logic                 en_wr;
  logic                 unused_bits;

  assign addr_hit = bus_sel_i && (bus_addr_i[ADDR_W-1:WORD_LSB] == WORD_IDX);
  assign wr_hit   = addr_hit && bus_we_i;
  assign rd_hit   = addr_hit && !bus_we_i;

  assign set_vec = {css_fail_i, src_ready_i};
  assign clr_vec = (wr_hit && bus_be_i[CLR_LANE]) ? bus_wdata_i[CLR_LSB +: NUM_FLAGS] : '0;
  assign en_wr   = wr_hit && bus_be_i[EN_LANE];

  assign unused_bits = ^{bus_wdata_i[DATA_W-1:CLR_LSB+NUM_FLAGS],
                         bus_wdata_i[CLR_LSB-1:EN_LSB+NUM_RDY],
                         bus_wdata_i[EN_LSB-1:0],
                         bus_addr_i[WORD_LSB-1:0], bus_be_i[FLAG_LANE], bus_be_i[LANES-1]};

  for (genvar k = 0; k < NUM_FLAGS; k++) begin : g_flag
    clkrdy_flag u_flag (
      .clk    (clk),
      .rst_n  (rst_n),
      .set_i  (set_vec[k]),
      .clr_i  (clr_vec[k]),
      .flag_o (flags[k])
    );
  end

  clkrdy_enable #(.N(NUM_RDY)) u_enable (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_i    (en_wr),
    .wdata_i (bus_wdata_i[EN_LSB +: NUM_RDY]),
    .en_o    (enables)
  );

  assign irq_ready_o = |(flags[NUM_RDY-1:0] & enables);
  assign irq_fail_o  = flags[FAIL_IDX];

  always_comb begin
    bus_rdata_o = '0;
    if (rd_hit) begin
      bus_rdata_o[NUM_FLAGS-1:0]        = flags;
      bus_rdata_o[EN_LSB +: NUM_RDY]    = enables;
    end
  end

  for (genvar k = 0; k < NUM_RDY; k++) begin : g_irq_chk
    assert_irq_ready_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (src_ready_i[k] && enables[k] && !en_wr) |=> irq_ready_o);
  end
  assert_fail_irq_R8: assert property (@(posedge clk) disable iff (!rst_n)
    css_fail_i |=> irq_fail_o);
  assert_reserved_zero_R5: assert property (@(posedge clk) disable iff (!rst_n)
    bus_rdata_o[DATA_W-1:EN_LSB+NUM_RDY] == '0);
  assert_addr_miss_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_hit |-> (bus_rdata_o == '0));
endmodule

// File: tb/clkrdy_intr_reg_bench.sv
module clkrdy_intr_reg_bench;
  localparam int CLK_PERIOD = 10;
  localparam logic [7:0] REG_ADDR = 8'h08;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [6:0]  src_ready = '0;
  logic        css_fail = 1'b0;
  logic        sel = 1'b0, we = 1'b0;
  logic [7:0]  addr = '0;
  logic [3:0]  be = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic        irq_ready, irq_fail;
  int          total = 0, bad = 0;
  bit          finished = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  clkrdy_intr_reg u_clkrdy_intr_reg (
    .clk(clk), .rst_n(rst_n), .src_ready_i(src_ready), .css_fail_i(css_fail),
    .bus_sel_i(sel), .bus_we_i(we), .bus_addr_i(addr), .bus_be_i(be),
    .bus_wdata_i(wdata), .bus_rdata_o(rdata),
    .irq_ready_o(irq_ready), .irq_fail_o(irq_fail)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // one cycle of stimulus: pulses and optional write share the same edge
  task automatic cycle(input logic [7:0] pulses, input logic do_wr,
                       input logic [7:0] a, input logic [3:0] strb, input logic [31:0] d);
    @(negedge clk);
    src_ready = pulses[6:0];
    css_fail  = pulses[7];
    sel = do_wr; we = do_wr; addr = a; be = strb; wdata = d;
    @(posedge clk);
    #1;
    src_ready = '0; css_fail = 1'b0; sel = 1'b0; we = 1'b0; be = '0; wdata = '0;
  endtask

  task automatic wr(input logic [7:0] a, input logic [3:0] strb, input logic [31:0] d);
    cycle(8'h00, 1'b1, a, strb, d);
  endtask

  task automatic pulse(input logic [7:0] p);
    cycle(p, 1'b0, REG_ADDR, 4'h0, 32'h0);
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] d);
    @(negedge clk);
    sel = 1'b1; we = 1'b0; addr = a;
    #1 d = rdata;
    sel = 1'b0;
  endtask

  task automatic t_reset;
    logic [31:0] d;
    rd(REG_ADDR, d);
    check("R1 reset word", d, 32'h0);
    check("R1 reset irqs", {30'h0, irq_ready, irq_fail}, 32'h0);
  endtask

  task automatic t_set_each;
    logic [31:0] d;
    for (int i = 0; i < 8; i++) begin
      pulse(8'(1 << i));
      rd(REG_ADDR, d);
      check("R2 flag accumulates", d, 32'((1 << (i + 1)) - 1));
    end
    wr(REG_ADDR, 4'b0100, 32'h00FF_0000);
    rd(REG_ADDR, d);
    check("R4 clear all flags", d, 32'h0);
  endtask

  task automatic t_enable_rw;
    logic [31:0] d;
    wr(REG_ADDR, 4'b0010, 32'h0000_FF00);
    rd(REG_ADDR, d);
    check("R3 enables read back, R5 bit15 zero", d, 32'h0000_7F00);
    wr(REG_ADDR, 4'b0010, 32'h0000_2A00);
    rd(REG_ADDR, d);
    check("R3 enable pattern", d, 32'h0000_2A00);
    wr(REG_ADDR, 4'b1111, 32'hFF00_0000);
    rd(REG_ADDR, d);
    check("R5 reserved and clear bits read 0", d, 32'h0);
  endtask

  task automatic t_clear_bits;
    logic [31:0] d;
    pulse(8'h09);
    wr(REG_ADDR, 4'b0100, 32'h0);
    rd(REG_ADDR, d);
    check("R4 zero clear no effect", d, 32'h0000_0009);
    wr(REG_ADDR, 4'b0100, 32'h0001_0000);
    rd(REG_ADDR, d);
    check("R4 single clear", d, 32'h0000_0008);
    wr(REG_ADDR, 4'b0100, 32'h0008_0000);
  endtask

  task automatic t_set_wins;
    logic [31:0] d;
    cycle(8'h04, 1'b1, REG_ADDR, 4'b0100, 32'h0004_0000);
    rd(REG_ADDR, d);
    check("R6 set beats clear", d, 32'h0000_0004);
    wr(REG_ADDR, 4'b0100, 32'h0004_0000);
    rd(REG_ADDR, d);
    check("R6 later clear works", d, 32'h0);
  endtask

  task automatic t_irq;
    wr(REG_ADDR, 4'b0010, 32'h0000_1000);
    pulse(8'h02);
    check("R7 masked flag no irq", {31'h0, irq_ready}, 32'h0);
    pulse(8'h10);
    check("R7 enabled flag irq", {31'h0, irq_ready}, 32'h1);
    wr(REG_ADDR, 4'b0100, 32'h0010_0000);
    check("R7 irq drops on clear", {31'h0, irq_ready}, 32'h0);
    wr(REG_ADDR, 4'b0110, 32'h0002_0000);
    pulse(8'h80);
    check("R8 fail irq unmasked", {30'h0, irq_ready, irq_fail}, 32'h1);
    wr(REG_ADDR, 4'b0100, 32'h0080_0000);
    check("R8 fail irq cleared", {31'h0, irq_fail}, 32'h0);
  endtask

  task automatic t_lanes;
    logic [31:0] d;
    wr(REG_ADDR, 4'b0010, 32'h0000_7F00);
    pulse(8'hFF);
    wr(REG_ADDR, 4'b0100, 32'hFFFF_FFFF);
    rd(REG_ADDR, d);
    check("R9 lane2 clears keep enables", d, 32'h0000_7F00);
    wr(REG_ADDR, 4'b0001, 32'h0000_00FF);
    rd(REG_ADDR, d);
    check("R9 lane0 not writable", d, 32'h0000_7F00);
    pulse(8'h01);
    wr(REG_ADDR, 4'b0010, 32'h00FF_0000);
    rd(REG_ADDR, d);
    check("R9 lane1 write leaves flags", d, 32'h0000_0001);
    wr(REG_ADDR, 4'b0100, 32'h0001_0000);
  endtask

  task automatic t_addr;
    logic [31:0] d;
    wr(8'h04, 4'b1111, 32'h00FF_7F00);
    rd(REG_ADDR, d);
    check("R10 other address write ignored", d, 32'h0);
    pulse(8'h01);
    rd(8'h0C, d);
    check("R10 other address reads 0", d, 32'h0);
    rd(REG_ADDR, d);
    check("R10 own address reads flag", d, 32'h1);
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    if (!finished) begin
      bad++; total++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    t_reset();
    t_set_each();
    t_enable_rw();
    t_clear_bits();
    t_set_wins();
    t_irq();
    t_lanes();
    t_addr();
    finished = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule